// File: doc/BRIEF.md
# SPI Master/Slave Byte Controller

This block moves one byte at a time over a four-wire serial peripheral link. It plays either side of the link. As master it makes the serial clock itself, shifts the outgoing byte out on MOSI and samples MISO into a receive buffer. As slave it follows a clock and a select line that come from outside, and it answers on MISO. Software drives it through three registers on a small read/write port: control, status and data.

A transfer in master mode begins when the data register is written. In slave mode the same write only loads the byte that the next exchange sends. A completion flag and a collision flag report progress. Both flags stay set until software reads the status register while a flag is set and then touches the data register. Clock polarity, clock phase, bit order and one of four clock dividers are set in the control register. The control layout is, from bit 7 to bit 0: interrupt enable, channel enable, LSB-first, master select, clock polarity, clock phase, and the two rate bits.

Top module: `spi_xcvr`

## Requirements
- R1: After reset the control register (select 0) reads 0x04 and the status register (select 1) reads 0x00. The status register has completion in bit 7 and collision in bit 6.
- R2: In master mode with the channel enabled, writing the data register (select 2) starts a byte. The completion flag rises exactly 8×N clocks after the write, where rate code 0/1/2/3 gives N = 4/16/64/128.
- R3: SCK rests at the clock polarity bit whenever no byte is shifting. The SCK output enable is high only while a master byte shifts. A byte makes exactly 16 SCK transitions.
- R4: With LSB-first at 1 the first MOSI bit is bit 0 of the byte. With LSB-first at 0 the first MOSI bit is bit 7. The first bit appears in the cycle after the write.
- R5: With phase 0, the master samples MISO on leading SCK edges and launches on trailing edges. With phase 1 it launches on leading edges and samples on trailing edges. With MISO looped to MOSI, the data register reads back the byte that was sent, in every polarity, phase and order.
- R6: `irq` equals the completion flag ANDed with the interrupt enable bit and the `irq_gate` input.
- R7: A data write while a byte is in progress sets the collision flag and changes neither the byte being shifted nor the received result.
- R8: The flags clear only on a data register read or write that follows a status read made while a flag was set. A data access with no such status read leaves them set. A completion in the same cycle as a clearing access leaves the completion flag set.
- R9: In slave mode, shifting follows the external SCK only while `sel_n_i` is low, with the same phase and order rules as R5. The received byte goes into the data register when the 16th edge arrives, and the loaded byte appears on MISO. The rate bits have no effect. SCK edges seen while the select is high do nothing, and MISO is driven only while the select is low.
- R10: With the channel enable at 0, a data write starts nothing, drives no SCK and sets no flag.
- R11: Reset does not change the received byte held in the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (its side effects on the flags) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq_gate | input | 1 | Global serial interrupt enable from outside the block |
| irq | output | 1 | Completion interrupt request |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock in (slave) |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | MOSI output enable |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | MISO output enable |
| miso_i | input | 1 | Master data in |
| sel_n_i | input | 1 | Slave select, active low |

## Verification
The completion of a byte and the access that clears the flags can fall in the same clock. To provoke this, the bench sets the collision flag with a write while the byte is busy, reads the status register, and then times a data read to land on the exact cycle of the 16th SCK edge at the fastest rate. The result is correct if collision ends up cleared and completion ends up set. The bench also places a data write inside a running byte. It judges the outcome by looping MISO back to MOSI and checking that the original byte comes back.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;
    localparam int BYTE_W = 8;
    localparam int EDGES  = 2 * BYTE_W;
    localparam int EDGE_W = $clog2(EDGES);
    // half SCK periods in system clocks for rate codes 0..3
    localparam int HALF0  = 2;
    localparam int HALF1  = 8;
    localparam int HALF2  = 32;
    localparam int HALF3  = 64;
    localparam int HALF_W = $clog2(HALF3);

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;

    typedef struct packed {
        logic       irq_en;
        logic       enable;
        logic       lsb_first;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = ctrl_t'(8'h04);

    function automatic logic [HALF_W-1:0] half_limit(input logic [1:0] code);
        case (code)
            2'd0:    half_limit = HALF_W'(HALF0 - 1);
            2'd1:    half_limit = HALF_W'(HALF1 - 1);
            2'd2:    half_limit = HALF_W'(HALF2 - 1);
            default: half_limit = HALF_W'(HALF3 - 1);
        endcase
    endfunction
endpackage

// File: rtl/spi_xcvr_sckgen.sv
module spi_xcvr_sckgen
    import spi_xcvr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       halt,
    input  logic       stop,
    input  logic [1:0] rate,
    input  logic       cpol,
    output logic       busy,
    output logic       sck,
    output logic       edge_stb
);
    typedef struct packed {
        logic              busy;
        logic              sck;
        logic [HALF_W-1:0] cnt;
    } gen_t;

    gen_t g_d, g_q;
    logic tick;

    always_comb begin
        tick = g_q.busy && !halt && (g_q.cnt == half_limit(rate));
        g_d  = g_q;
        if (halt) begin
            g_d.busy = 1'b0;
            g_d.cnt  = '0;
            g_d.sck  = cpol;
        end else if (start) begin
            g_d.busy = 1'b1;
            g_d.cnt  = '0;
            g_d.sck  = cpol;
        end else if (g_q.busy) begin
            if (tick) begin
                g_d.cnt = '0;
                g_d.sck = ~g_q.sck;
                if (stop) g_d.busy = 1'b0;
            end else begin
                g_d.cnt = g_q.cnt + 1'b1;
            end
        end else begin
            g_d.sck = cpol;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign busy     = g_q.busy;
    assign sck      = g_q.sck;
    assign edge_stb = tick;
endmodule

// File: rtl/spi_xcvr_slvfront.sv
module spi_xcvr_slvfront (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic mosi_i,
    input  logic sel_n_i,
    output logic sck_edge,
    output logic sel_act,
    output logic mosi_s
);
    typedef struct packed {
        logic sck_m, sck_s, sck_p;
        logic mosi_m, mosi_s;
        logic sel_m, sel_s;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.sck_m  = sck_i;
        s_d.sck_s  = s_q.sck_m;
        s_d.sck_p  = s_q.sck_s;
        s_d.mosi_m = mosi_i;
        s_d.mosi_s = s_q.mosi_m;
        s_d.sel_m  = sel_n_i;
        s_d.sel_s  = s_q.sel_m;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{sel_m: 1'b1, sel_s: 1'b1, default: 1'b0};
        else        s_q <= s_d;
    end

    assign sck_edge = s_q.sck_s ^ s_q.sck_p;
    assign sel_act  = ~s_q.sel_s;
    assign mosi_s   = s_q.mosi_s;
endmodule

// File: rtl/spi_xcvr_bitseq.sv
module spi_xcvr_bitseq
    import spi_xcvr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              edge_stb,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    input  logic              in_bit,
    output logic              out_bit,
    output logic              done,
    output logic              mid_byte,
    output logic [BYTE_W-1:0] rx_next
);
    typedef struct packed {
        logic [EDGE_W-1:0] edge_cnt;
    } seq_t;

    typedef struct packed {
        logic [BYTE_W-1:0] tx_sr;
        logic [BYTE_W-1:0] rx_sr;
    } dat_t;

    seq_t c_d, c_q;
    dat_t x_d, x_q;
    logic leading, do_sample, do_shift, last;

    always_comb begin
        leading   = ~c_q.edge_cnt[0];
        do_sample = edge_stb && (cpha ? !leading : leading);
        do_shift  = edge_stb && (cpha ? (leading && c_q.edge_cnt != '0) : !leading);
        last      = edge_stb && (c_q.edge_cnt == EDGE_W'(EDGES - 1));

        c_d = c_q;
        if (clear || last)  c_d.edge_cnt = '0;
        else if (edge_stb)  c_d.edge_cnt = c_q.edge_cnt + 1'b1;

        x_d = x_q;
        if (load)
            x_d.tx_sr = load_data;
        else if (do_shift)
            x_d.tx_sr = lsb_first ? (x_q.tx_sr >> 1) : (x_q.tx_sr << 1);
        if (do_sample)
            x_d.rx_sr = lsb_first ? {in_bit, x_q.rx_sr[BYTE_W-1:1]}
                                  : {x_q.rx_sr[BYTE_W-2:0], in_bit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    // shift data carries no reset
    always_ff @(posedge clk) begin
        x_q <= x_d;
    end

    assign out_bit  = lsb_first ? x_q.tx_sr[0] : x_q.tx_sr[BYTE_W-1];
    assign done     = last;
    assign mid_byte = (c_q.edge_cnt != '0);
    assign rx_next  = x_d.rx_sr;
endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
    import spi_xcvr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] reg_sel,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       irq_gate,
    output logic       irq,
    output logic       sck_o,
    output logic       sck_oe,
    input  logic       sck_i,
    output logic       mosi_o,
    output logic       mosi_oe,
    input  logic       mosi_i,
    output logic       miso_o,
    output logic       miso_oe,
    input  logic       miso_i,
    input  logic       sel_n_i
);
    typedef struct packed {
        ctrl_t ctrl;
        logic  done_f;
        logic  col_f;
        logic  arm;
    } top_t;

    top_t st_d, st_q;
    logic [BYTE_W-1:0] rx_buf_d, rx_buf_q;

    logic en, is_master;
    logic data_wr, data_acc, stat_rd, ctrl_wr;
    logic busy_now, accept, collide, start;
    logic gen_busy, gen_sck, gen_edge;
    logic slv_edge, slv_act, slv_mosi;
    logic seq_edge, seq_clear, seq_in, seq_out, seq_done, seq_mid;
    logic [BYTE_W-1:0] seq_rx;
    logic done_flag, col_flag, arm_flag, cpol_q;

    assign en        = st_q.ctrl.enable;
    assign is_master = st_q.ctrl.master;
    assign ctrl_wr   = reg_wr && (reg_sel == SEL_CTRL);
    assign stat_rd   = reg_rd && (reg_sel == SEL_STAT);
    assign data_wr   = reg_wr && (reg_sel == SEL_DATA);
    assign data_acc  = (reg_wr || reg_rd) && (reg_sel == SEL_DATA);
    assign busy_now  = is_master ? gen_busy : (slv_act && seq_mid);
    assign accept    = data_wr && en && !busy_now;
    assign collide   = data_wr && en && busy_now;
    assign start     = accept && is_master;
    assign seq_edge  = en && (is_master ? gen_edge : (slv_act && slv_edge));
    assign seq_clear = !en || (is_master ? !gen_busy : !slv_act);
    assign seq_in    = is_master ? miso_i : slv_mosi;

    spi_xcvr_sckgen u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .halt     (!en || !is_master),
        .stop     (seq_done),
        .rate     (st_q.ctrl.rate),
        .cpol     (st_q.ctrl.cpol),
        .busy     (gen_busy),
        .sck      (gen_sck),
        .edge_stb (gen_edge)
    );

    spi_xcvr_slvfront u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_i    (sck_i),
        .mosi_i   (mosi_i),
        .sel_n_i  (sel_n_i),
        .sck_edge (slv_edge),
        .sel_act  (slv_act),
        .mosi_s   (slv_mosi)
    );

    spi_xcvr_bitseq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (seq_clear),
        .edge_stb  (seq_edge),
        .cpha      (st_q.ctrl.cpha),
        .lsb_first (st_q.ctrl.lsb_first),
        .load      (accept),
        .load_data (reg_wdata),
        .in_bit    (seq_in),
        .out_bit   (seq_out),
        .done      (seq_done),
        .mid_byte  (seq_mid),
        .rx_next   (seq_rx)
    );

    always_comb begin
        st_d     = st_q;
        rx_buf_d = rx_buf_q;
        if (ctrl_wr) st_d.ctrl = ctrl_t'(reg_wdata);
        if (stat_rd && (st_q.done_f || st_q.col_f)) st_d.arm = 1'b1;
        if (data_acc) begin
            if (st_q.arm) begin
                st_d.done_f = 1'b0;
                st_d.col_f  = 1'b0;
            end
            st_d.arm = 1'b0;
        end
        // new events win over a clear in the same cycle
        if (seq_done) begin
            st_d.done_f = 1'b1;
            rx_buf_d    = seq_rx;
        end
        if (collide) st_d.col_f = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ctrl: CTRL_RST, default: 1'b0};
        else        st_q <= st_d;
    end

    // received byte survives reset
    always_ff @(posedge clk) begin
        rx_buf_q <= rx_buf_d;
    end

    always_comb begin
        case (reg_sel)
            SEL_CTRL: reg_rdata = st_q.ctrl;
            SEL_STAT: reg_rdata = {st_q.done_f, st_q.col_f, 6'b0};
            SEL_DATA: reg_rdata = rx_buf_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign done_flag = st_q.done_f;
    assign col_flag  = st_q.col_f;
    assign arm_flag  = st_q.arm;
    assign cpol_q    = st_q.ctrl.cpol;

    assign irq     = st_q.done_f && st_q.ctrl.irq_en && irq_gate;
    assign sck_o   = gen_sck;
    assign sck_oe  = is_master && en && gen_busy;
    assign mosi_o  = seq_out;
    assign mosi_oe = is_master && en;
    assign miso_o  = seq_out;
    assign miso_oe = !is_master && en && slv_act;
endmodule

// File: rtl/spi_xcvr_chk.sv
module spi_xcvr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] reg_sel,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic       irq,
    input logic       irq_gate,
    input logic       done_flag,
    input logic       col_flag,
    input logic       arm_flag,
    input logic       cpol_q,
    input logic       sck_o,
    input logic       sck_oe,
    input logic       miso_oe
);
    logic data_acc;
    assign data_acc = (reg_wr || reg_rd) && (reg_sel == 2'd2);

    p_irq_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done_flag && irq_gate));

    p_done_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !(arm_flag && data_acc)) |=> done_flag);

    p_done_clear_seq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_flag) |-> $past(arm_flag && data_acc));

    p_col_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (col_flag && !(arm_flag && data_acc)) |=> col_flag);

    p_sck_rest_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sck_oe) |-> (sck_o == cpol_q));

    p_one_side_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(sck_oe && miso_oe));
endmodule

bind spi_xcvr spi_xcvr_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .irq       (irq),
    .irq_gate  (irq_gate),
    .done_flag (done_flag),
    .col_flag  (col_flag),
    .arm_flag  (arm_flag),
    .cpol_q    (cpol_q),
    .sck_o     (sck_o),
    .sck_oe    (sck_oe),
    .miso_oe   (miso_oe)
);

// File: tb/spi_xcvr_bench.sv
module spi_xcvr_bench;
    import spi_xcvr_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_sel = SEL_STAT;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_gate = 1'b0, irq;
    logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
    logic       sck_i = 1'b0, mosi_i = 1'b0, sel_n_i = 1'b1;
    logic       loop_en = 1'b1;
    logic       miso_i;
    int         checks = 0, errors = 0;

    assign miso_i = loop_en ? mosi_o : 1'b0;

    always #5 clk = ~clk;

    spi_xcvr u_spi_xcvr (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_gate(irq_gate), .irq(irq),
        .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .mosi_i(mosi_i), .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i), .sel_n_i(sel_n_i)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int clk_div(input int code);
        case (code)
            0: clk_div = 4;
            1: clk_div = 16;
            2: clk_div = 64;
            default: clk_div = 128;
        endcase
    endfunction

    function automatic int bit_at(input int step, input bit lsb);
        bit_at = lsb ? step : 7 - step;
    endfunction

    // called at a falling edge; one register access consumes the next rising edge
    task automatic acc(input logic [1:0] s, input bit w, input bit r,
                       input logic [7:0] wd, output logic [7:0] rv);
        reg_sel = s; reg_wr = w; reg_rd = r; reg_wdata = wd;
        #1 rv = reg_rdata;
        @(negedge clk);
        reg_sel = SEL_STAT; reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(output logic [7:0] v);
        #1 v = reg_rdata;
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        summary();
    end

    initial begin
        logic [7:0] v, d, r, m;
        bit cpol, cpha, lsb, glb, coll;
        int n, tog;
        logic prev;
        void'($urandom(32'h1c3a_55e1));

        idle(3);
        rst_n = 1'b1;
        idle(1);
        acc(SEL_CTRL, 0, 0, 8'h00, v); chk(v == 8'h04, "R1 ctrl", v, 8'h04);
        acc(SEL_STAT, 0, 0, 8'h00, v); chk(v == 8'h00, "R1 status", v, 8'h00);

        // R10: channel disabled, write ignored
        acc(SEL_CTRL, 1, 0, 8'h10, v);
        acc(SEL_DATA, 1, 0, 8'hA5, v);
        tog = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (sck_oe) tog++;
        end
        chk(tog == 0, "R10 sck_oe", tog, 0);
        peek(v); chk(v == 8'h00, "R10 status", v, 8'h00);

        // master transfers in loopback
        for (int i = 0; i < 16; i++) begin
            d = 8'($urandom);
            cpol = 1'($urandom); cpha = 1'($urandom); lsb = 1'($urandom);
            glb = 1'($urandom); coll = (i % 3 == 0);
            n = clk_div(i % 4);
            irq_gate = glb;
            acc(SEL_CTRL, 1, 0, {1'b1, 1'b1, lsb, 1'b1, cpol, cpha, 2'(i % 4)}, v);
            idle(1);
            chk(sck_o == cpol && !sck_oe, "R3 idle", {sck_oe, sck_o}, {1'b0, cpol});
            acc(SEL_DATA, 1, 0, d, v);
            chk(mosi_o == d[bit_at(0, lsb)], "R4 first bit", mosi_o, d[bit_at(0, lsb)]);
            chk(sck_oe == 1'b1, "R3 oe", sck_oe, 1);
            prev = sck_o; tog = 0;
            for (int k = 1; k < 8 * n; k++) begin
                if (coll && k == 3) begin
                    reg_sel = SEL_DATA; reg_wr = 1'b1; reg_wdata = ~d;
                end
                @(negedge clk);
                reg_sel = SEL_STAT; reg_wr = 1'b0;
                if (sck_o != prev) tog++;
                prev = sck_o;
            end
            peek(v); chk(v[7] == 1'b0, "R2 early", v[7], 0);
            @(negedge clk);
            if (sck_o != prev) tog++;
            peek(v);
            chk(v == {1'b1, coll, 6'b0}, "R2 done flag", v, {1'b1, coll, 6'b0});
            chk(tog == 16, "R3 toggles", tog, 16);
            chk(!sck_oe && sck_o == cpol, "R3 rest", {sck_oe, sck_o}, {1'b0, cpol});
            chk(irq == glb, "R6 irq", irq, glb);
            if (i % 2 == 1) begin
                acc(SEL_DATA, 0, 1, 8'h00, r);
                peek(v); chk(v[7] == 1'b1, "R8 no clear", v, 8'h80);
            end
            acc(SEL_STAT, 0, 1, 8'h00, v);
            acc(SEL_DATA, 0, 1, 8'h00, r);
            chk(r == d, coll ? "R7 ignored write" : "R5 loopback", r, d);
            peek(v); chk(v == 8'h00, "R8 cleared", v, 8'h00);
            chk(irq == 1'b0, "R6 irq low", irq, 0);
        end

        // R8: completion lands in the same cycle as the clearing access
        d = 8'h3C;
        acc(SEL_CTRL, 1, 0, 8'hD0, v);
        idle(1);
        acc(SEL_DATA, 1, 0, d, v);
        acc(SEL_DATA, 1, 0, 8'hFF, v);
        acc(SEL_STAT, 0, 1, 8'h00, v);
        idle(29);
        acc(SEL_DATA, 0, 1, 8'h00, v);
        peek(v); chk(v == 8'h80, "R8 same cycle", v, 8'h80);
        acc(SEL_STAT, 0, 1, 8'h00, v);
        acc(SEL_DATA, 0, 1, 8'h00, r);
        chk(r == d, "R7 same cycle data", r, d);

        // slave transfers
        loop_en = 1'b0;
        for (int i = 0; i < 8; i++) begin
            d = 8'($urandom); r = 8'($urandom); m = 8'h00;
            cpol = 1'($urandom); cpha = 1'($urandom); lsb = 1'($urandom);
            sck_i = cpol;
            acc(SEL_CTRL, 1, 0, {1'b0, 1'b1, lsb, 1'b0, cpol, cpha, 2'($urandom)}, v);
            acc(SEL_DATA, 1, 0, d, v);
            idle(2);
            sel_n_i = 1'b0;
            idle(8);
            for (int b = 0; b < 8; b++) begin
                if (!cpha) begin
                    mosi_i = r[bit_at(b, lsb)];
                    idle(8);
                    m[bit_at(b, lsb)] = miso_o;
                    sck_i = ~cpol; idle(8); sck_i = cpol;
                end else begin
                    sck_i = ~cpol; mosi_i = r[bit_at(b, lsb)];
                    idle(8);
                    m[bit_at(b, lsb)] = miso_o;
                    sck_i = cpol; idle(8);
                end
            end
            idle(8);
            chk(miso_oe == 1'b1, "R9 miso driven", miso_oe, 1);
            chk(m == d, "R9 miso byte", m, d);
            peek(v); chk(v[7] == 1'b1, "R9 done", v, 8'h80);
            sel_n_i = 1'b1;
            idle(4);
            chk(miso_oe == 1'b0, "R9 miso released", miso_oe, 0);
            acc(SEL_STAT, 0, 1, 8'h00, v);
            acc(SEL_DATA, 0, 1, 8'h00, v);
            chk(v == r, "R9 received", v, r);
        end

        // R9: edges while deselected do nothing
        for (int e = 0; e < 16; e++) begin
            sck_i = ~sck_i; idle(8);
        end
        peek(v); chk(v == 8'h00, "R9 deselected", v, 8'h00);

        // R11: received byte survives reset
        rst_n = 1'b0; idle(3); rst_n = 1'b1; idle(1);
        acc(SEL_CTRL, 0, 0, 8'h00, v); chk(v == 8'h04, "R1 ctrl after reset", v, 8'h04);
        acc(SEL_DATA, 0, 0, 8'h00, v); chk(v == r, "R11 data kept", v, r);

        summary();
    end
endmodule